// File: doc/BRIEF.md
# Time-Varying Convolutional LDPC Encoder (rate 1/2)

This block encodes a stream of information bits with a regular (3,6) rate-1/2 low-density parity-check convolutional code. Each information bit presented with the input strobe produces one output pair: the bit itself and a parity bit. The parity bit is the modulo-2 sum of five earlier bits, all taken from two shift-register histories. One history holds past information bits and the other holds past parity bits. The code memory `MEM` sets the period of a phase counter. The counter picks, through multiplexers, which history positions feed the sum, so four of the five taps move from one bit to the next. Only the tap reaching back exactly `MEM` parity bits stays fixed.

The per-phase tap delays are four compile-time parameter tables with `MEM` entries each. One table is for the moving parity tap and three are for the information taps. Every entry must lie in 1..`MEM-1`, and `MEM` must be at least 3. With `PIPE` set, a register stage holds the five selected terms ahead of the XOR. The parity history then loses its first register, because the XOR result itself serves as the most recent parity bit. This keeps the code sequence unchanged and costs one extra cycle of latency.

Top module: `ldpc_conv_encoder`

## Requirements
- R1: Each accepted input bit appears on `out_info` exactly once, in arrival order, qualified by `out_valid`.
- R2: `out_valid` is `in_valid` delayed by one cycle when `PIPE`=0 and by two cycles when `PIPE`=1.
- R3: The parity bit for the t-th accepted bit (t counted from 0 after reset, with phase p = t mod `MEM`) is the XOR of five terms: v(t-`MEM`), v(t-`CODE_DLY`[p]), u(t-`INFO_DLY_A`[p]), u(t-`INFO_DLY_B`[p]) and u(t-`INFO_DLY_C`[p]). Here u is the information bit and v is the parity bit, and any term with a negative index is 0. As a result, the first parity bit after reset is 0.
- R4: The phase starts at 0, advances by one on every accepted bit, and wraps from `MEM`-1 to 0.
- R5: Cycles with `in_valid` low change neither the histories nor the phase, so a stream with idle gaps yields the same code sequence as the same bits sent back to back.
- R6: Synchronous reset clears both histories, sets the phase to 0 and drives `out_valid` low, so encoding restarts from an all-zero state.
- R7: The pipelined variant (`PIPE`=1) produces the same information and parity sequence as the plain variant for any input.
- R8: While `rst` is high, `in_valid` is ignored: no output is produced and the state after reset is all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit strobe |
| in_info | input | 1 | Information bit |
| out_valid | output | 1 | Output pair strobe |
| out_info | output | 1 | Information bit passed through |
| out_code | output | 1 | Parity bit |

## Verification
The bench drives a plain and a pipelined instance side by side with an impulse, a pseudo-random stream, an all-ones run and a stream with random idle gaps. Every output is compared with a model that evaluates the parity equation from its own bit history. The impulse response over several full phase periods exposes a wrong table index or a tap one position off: the single one would then reappear at wrong times. The gapped stream catches a phase or history that moves on idle cycles, which would scramble every later parity bit. The pipelined instance catches a parity history left at full length, which would offset the moving parity tap by one. Holding `in_valid` high during reset checks that no bit leaks into the state, since a leaked bit would corrupt the first outputs after release.

// File: rtl/ldpc_conv_pkg.sv
package ldpc_conv_pkg;

  // The five terms that feed one parity bit.
  typedef struct packed {
    logic code_far;  // parity bit MEM steps back (fixed tap)
    logic code_sel;  // phase-selected earlier parity bit
    logic info_a;    // phase-selected earlier information bits
    logic info_b;
    logic info_c;
  } tap_terms_t;

  function automatic logic parity_of(input tap_terms_t t);
    return ^t;
  endfunction

  // Next phase value for a counter of period mem.
  function automatic int unsigned phase_after(input int unsigned ph, input int unsigned mem);
    return (ph == mem - 1) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/ldpc_conv_phase.sv
module ldpc_conv_phase
  import ldpc_conv_pkg::*;
#(
  parameter int unsigned MEM = 8,
  parameter int unsigned PW  = $clog2(MEM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [PW-1:0] phase,
  output logic          wrap
);

  localparam logic [PW-1:0] LAST = PW'(MEM - 1);

  assign wrap = step && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (step) begin
      phase <= PW'(phase_after(int'(phase), MEM));
    end
  end

endmodule

// File: rtl/ldpc_conv_shiftline.sv
module ldpc_conv_shiftline #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  output logic [DEPTH-1:0] taps   // taps[k] holds the bit shifted in k+1 shifts ago
);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (shift) begin
      taps <= {taps[DEPTH-2:0], din};
    end
  end

endmodule

// File: rtl/ldpc_conv_tapsel.sv
module ldpc_conv_tapsel #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [W-1:0]  vec,
  input  logic [IW-1:0] dly,   // 1-based delay: 1 picks vec[0]
  output logic          bit_o
);

  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (int'(dly) == k + 1) bit_o = vec[k];
    end
  end

endmodule

// File: rtl/ldpc_conv_encoder.sv
module ldpc_conv_encoder
  import ldpc_conv_pkg::*;
#(
  parameter int unsigned MEM = 8,
  parameter bit          PIPE = 1'b0,
  parameter int unsigned CODE_DLY   [MEM] = '{3, 5, 2, 7, 1, 4, 6, 2},
  parameter int unsigned INFO_DLY_A [MEM] = '{1, 2, 3, 4, 5, 6, 7, 1},
  parameter int unsigned INFO_DLY_B [MEM] = '{4, 6, 1, 3, 7, 2, 5, 3},
  parameter int unsigned INFO_DLY_C [MEM] = '{7, 3, 5, 1, 2, 4, 6, 6}
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_info,
  output logic out_valid,
  output logic out_info,
  output logic out_code
);

  localparam int unsigned PW    = $clog2(MEM);
  localparam int unsigned ILINE = MEM - 1;
  localparam int unsigned CLINE = PIPE ? MEM - 1 : MEM;

  // Named internal events for the checker.
  logic          accept;
  logic [PW-1:0] phase_q;
  logic          phase_wrap;
  logic          new_code;

  logic [ILINE-1:0] info_hist;
  logic [CLINE-1:0] code_line;
  logic [MEM-1:0]   code_ext;   // code_ext[k] = parity bit k+1 steps back
  logic [PW-1:0]    dly_code, dly_a, dly_b, dly_c;
  tap_terms_t       terms_d;

  assign accept = in_valid;

  ldpc_conv_phase #(.MEM(MEM), .PW(PW)) u_phase (
    .clk(clk), .rst(rst), .step(accept), .phase(phase_q), .wrap(phase_wrap)
  );

  ldpc_conv_shiftline #(.DEPTH(ILINE)) u_info_line (
    .clk(clk), .rst(rst), .shift(accept), .din(in_info), .taps(info_hist)
  );

  ldpc_conv_shiftline #(.DEPTH(CLINE)) u_code_line (
    .clk(clk), .rst(rst), .shift(accept), .din(new_code), .taps(code_line)
  );

  always_comb begin
    dly_code = PW'(CODE_DLY[phase_q]);
    dly_a    = PW'(INFO_DLY_A[phase_q]);
    dly_b    = PW'(INFO_DLY_B[phase_q]);
    dly_c    = PW'(INFO_DLY_C[phase_q]);
  end

  ldpc_conv_tapsel #(.W(MEM), .IW(PW)) u_sel_code (
    .vec(code_ext), .dly(dly_code), .bit_o(terms_d.code_sel)
  );
  ldpc_conv_tapsel #(.W(ILINE), .IW(PW)) u_sel_a (
    .vec(info_hist), .dly(dly_a), .bit_o(terms_d.info_a)
  );
  ldpc_conv_tapsel #(.W(ILINE), .IW(PW)) u_sel_b (
    .vec(info_hist), .dly(dly_b), .bit_o(terms_d.info_b)
  );
  ldpc_conv_tapsel #(.W(ILINE), .IW(PW)) u_sel_c (
    .vec(info_hist), .dly(dly_c), .bit_o(terms_d.info_c)
  );

  assign terms_d.code_far = code_ext[MEM-1];

  generate
    if (PIPE) begin : g_pipe
      tap_terms_t terms_q;
      logic       stage_info_q;
      logic       stage_vld_q;

      // XOR result of the staged terms is the newest parity bit,
      // standing in for the register removed from the parity history.
      assign new_code = parity_of(terms_q);
      assign code_ext = {code_line, new_code};

      always_ff @(posedge clk) begin
        if (rst) begin
          terms_q      <= '0;
          stage_info_q <= 1'b0;
          stage_vld_q  <= 1'b0;
          out_valid    <= 1'b0;
          out_info     <= 1'b0;
          out_code     <= 1'b0;
        end else begin
          stage_vld_q <= accept;
          if (accept) begin
            terms_q      <= terms_d;
            stage_info_q <= in_info;
          end
          out_valid <= stage_vld_q;
          if (stage_vld_q) begin
            out_info <= stage_info_q;
            out_code <= new_code;
          end
        end
      end
    end else begin : g_plain
      assign new_code = parity_of(terms_d);
      assign code_ext = code_line;

      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_info  <= 1'b0;
          out_code  <= 1'b0;
        end else begin
          out_valid <= accept;
          if (accept) begin
            out_info <= in_info;
            out_code <= new_code;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ldpc_conv_encoder_chk.sv
module ldpc_conv_encoder_chk #(
  parameter int unsigned MEM  = 8,
  parameter bit          PIPE = 1'b0,
  parameter int unsigned PW   = $clog2(MEM)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_info,
  input logic          out_valid,
  input logic          out_info,
  input logic          out_code,
  input logic          accept,
  input logic          phase_wrap,
  input logic [PW-1:0] phase
);

  localparam logic [PW-1:0] LAST = PW'(MEM - 1);

  logic [1:0] age;       // clean cycles since reset, saturating
  logic       seen_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= 2'd0;
      seen_out <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (out_valid) seen_out <= 1'b1;
    end
  end

  // R6
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && phase == '0));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && phase != LAST) |=> (phase == $past(phase) + 1'b1));

  // R4
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    phase_wrap |=> (phase == '0));

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(phase));

  // R3
  first_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !seen_out) |-> !out_code);

  generate
    if (PIPE) begin : g_pipe
      // R2
      valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
      // R1
      info_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && out_valid) |-> (out_info == $past(in_info, 2)));
    end else begin : g_plain
      // R2
      valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) |-> (out_valid == $past(in_valid)));
      // R1
      info_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && out_valid) |-> (out_info == $past(in_info)));
    end
  endgenerate

endmodule

bind ldpc_conv_encoder ldpc_conv_encoder_chk #(.MEM(MEM), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_info(in_info),
  .out_valid(out_valid), .out_info(out_info), .out_code(out_code),
  .accept(accept), .phase_wrap(phase_wrap), .phase(phase_q)
);

// File: tb/ldpc_conv_encoder_bench.sv
module ldpc_conv_encoder_bench;

  localparam int unsigned MEM = 8;
  localparam int unsigned CT [MEM] = '{3, 5, 2, 7, 1, 4, 6, 2};
  localparam int unsigned TA [MEM] = '{1, 2, 3, 4, 5, 6, 7, 1};
  localparam int unsigned TB [MEM] = '{4, 6, 1, 3, 7, 2, 5, 3};
  localparam int unsigned TC [MEM] = '{7, 3, 5, 1, 2, 4, 6, 6};
  localparam int NMAX = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_info = 1'b0;
  logic v0, i0, c0, v1, i1, c1;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string sect = "R6 reset";

  always #10 clk = ~clk;

  ldpc_conv_encoder #(.MEM(MEM), .PIPE(1'b0), .CODE_DLY(CT), .INFO_DLY_A(TA),
                      .INFO_DLY_B(TB), .INFO_DLY_C(TC)) u_ldpc_conv_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_info(in_info),
    .out_valid(v0), .out_info(i0), .out_code(c0)
  );

  ldpc_conv_encoder #(.MEM(MEM), .PIPE(1'b1), .CODE_DLY(CT), .INFO_DLY_A(TA),
                      .INFO_DLY_B(TB), .INFO_DLY_C(TC)) u_ldpc_conv_encoder_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_info(in_info),
    .out_valid(v1), .out_info(i1), .out_code(c1)
  );

  // Behavioural model: histories indexed by accepted-bit count.
  bit mu [NMAX];
  bit mv [NMAX];
  int n = 0;
  int rd0 = 0;
  int rd1 = 0;
  bit h1 = 0;
  bit h2 = 0;

  function automatic bit u_at(int idx);
    return (idx < 0) ? 1'b0 : mu[idx];
  endfunction
  function automatic bit v_at(int idx);
    return (idx < 0) ? 1'b0 : mv[idx];
  endfunction
  function automatic bit model_code(int t);
    int p;
    p = t % MEM;
    return v_at(t - MEM) ^ v_at(t - int'(CT[p])) ^ u_at(t - int'(TA[p]))
         ^ u_at(t - int'(TB[p])) ^ u_at(t - int'(TC[p]));
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s]: actual=%0b expected=%0b", tag, sect, act, exp);
    end
  endtask

  always @(posedge clk) begin
    h1 <= in_valid && !rst;
    h2 <= h1 && !rst;
    if (rst) begin
      n = 0;
    end else if (in_valid && n < NMAX) begin
      mu[n] = in_info;
      mv[n] = model_code(n);
      n++;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      rd0 = 0;
      rd1 = 0;
    end
    chk(v0, h1, "R2 plain valid");
    chk(v1, h2, "R2 pipe valid");
    if (v0 === 1'b1) begin
      chk(i0, mu[rd0], "R1 plain info");
      chk(c0, mv[rd0], "R3/R4 plain code");
      rd0++;
    end
    if (v1 === 1'b1) begin
      chk(i1, mu[rd1], "R1 pipe info");
      chk(c1, mv[rd1], "R7 pipe code");
      rd1++;
    end
  end

  task automatic drive(input bit v, input bit b);
    @(posedge clk);
    #1;
    in_valid = v;
    in_info = b;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic drain_and_count(input string tag);
    repeat (4) drive(1'b0, 1'b0);
    @(negedge clk);
    chk(rd0 == n, 1'b1, tag);
    chk(rd1 == n, 1'b1, tag);
  endtask

  initial begin
    repeat (3) drive(1'b0, 1'b0);
    @(negedge clk);
    // R6: reset state
    chk(v0, 1'b0, "R6 reset out_valid");
    chk(v1, 1'b0, "R6 reset out_valid pipe");
    chk(c0, 1'b0, "R6 reset out_code");
    #1 rst = 1'b0;

    sect = "R3 impulse";
    drive(1'b1, 1'b1);
    repeat (3 * MEM) drive(1'b1, 1'b0);
    drain_and_count("R1 impulse count");

    sect = "R3 prbs";
    repeat (300) begin
      lfsr_step();
      drive(1'b1, lfsr[0]);
    end
    sect = "R3 ones";
    repeat (40) drive(1'b1, 1'b1);
    drain_and_count("R4 continuous count");

    sect = "R5 gaps";
    repeat (300) begin
      lfsr_step();
      drive(lfsr[3] | lfsr[7], lfsr[0]);
    end
    drain_and_count("R5 gapped count");

    sect = "R8 reset with valid";
    @(posedge clk);
    #1 rst = 1'b1;
    repeat (5) begin
      lfsr_step();
      drive(1'b1, 1'b1);
    end
    @(negedge clk);
    chk(v0, 1'b0, "R8 no output in reset");
    chk(v1, 1'b0, "R8 no output in reset pipe");
    @(posedge clk);
    #1 rst = 1'b0;
    sect = "R6 restart";
    repeat (2 * MEM + 5) begin
      lfsr_step();
      drive(1'b1, lfsr[0]);
    end
    drain_and_count("R6 restart count");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule